// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes three serial stereo data lines. The lines share one bit clock and one frame (word-select) clock. From each line it recovers a left sample and a right sample. All samples come out as 32-bit two's-complement words on a single parallel bus, with a one-cycle valid strobe and a channel flag. Two static select inputs pick the frame layout and the word length. The supported layouts are:

- right-justified, where the sample sits against the end of each half-frame;
- I2S-style left-justified, where the MSB follows the frame-clock change after one bit of delay.

The serial clocks are slow compared with the system clock. The block passes the bit clock, the frame clock and the data lines through one synchronizer together. Bit-clock rising edges are then found in the system-clock domain, so every sample is already in that domain when its valid strobe is raised. A sample is reported when the frame clock next changes level. That change marks the end of the half-frame that carried the sample.

Top module: `sar_rx`

## Requirements
- R1: The select pair {fmt_sel, len_sel} picks the mode: 2'b00 right-justified 24-bit, 2'b01 right-justified 20-bit, 2'b10 I2S 16-bit, 2'b11 I2S with up to 32 bits.
- R2: Words arrive MSB first in two's complement. In 24-, 20- and 16-bit modes, the bits of the 32-bit output above the word are copies of the word's sign bit.
- R3: In right-justified modes, frame clock high carries the left channel and low carries the right channel. smp_right is 0 for a left sample and 1 for a right sample.
- R4: In I2S modes, frame clock low carries the left channel and high carries the right channel, with the same smp_right encoding.
- R5: In right-justified modes, the last N bits sampled before a frame-clock change form the word, where N is 24 or 20. Bits earlier in that half-frame have no effect on the output.
- R6: In I2S modes, the MSB is the bit sampled one bit clock after the frame-clock change. The bit sampled at the change itself is the last bit position of the previous word.
- R7: In the up-to-32-bit I2S mode, bits after the 32nd in a half-frame are discarded. A half-frame shorter than 32 bits gives a left-aligned word with zeros below it.
- R8: All three lines are sampled on the same bit-clock edge. The sample from line k appears on smp_data[32k+31:32k].
- R9: Each completed half-frame produces exactly one smp_valid pulse, one cycle wide, for all three lines together. Successive pulses alternate channel.
- R10: After reset, the first frame-clock change only arms the receiver. The half-frame in progress at reset is never reported.
- R11: During and right after reset, smp_valid, smp_right and smp_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Serial bit clock; data sampled on its rising edge |
| ws_in | input | 1 | Frame clock selecting left/right half-frame |
| sd_in | input | 3 | Serial data lines, one per stereo pair |
| fmt_sel | input | 1 | 0 right-justified, 1 I2S |
| len_sel | input | 1 | Word-length select within the format |
| smp_data | output | 96 | Three sign-extended 32-bit samples, line 0 in the low bits |
| smp_right | output | 1 | Channel of the current samples, 1 = right |
| smp_valid | output | 1 | One-cycle strobe: smp_data and smp_right are new |

## Verification
Some properties are checked on every cycle:

- the valid strobe is never longer than one cycle;
- successive strobes alternate channel;
- no strobe appears before the receiver is armed;
- in the three shorter modes, the upper output bits always copy the word's sign bit.

Other properties are shown only by the bench scenarios:

- which bits of a half-frame make up the word in each mode;
- that padding bits in the right-justified layouts do not change the result;
- that bits after the 32nd are dropped;
- that short I2S words are zero-filled;
- that the channel follows the polarity of each format.

Each of these scenarios compares the output words with values computed from the serial stream the bench sends.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

    localparam int SMP_W = 32;
    localparam int IDX_W = $clog2(SMP_W);
    localparam int CNT_W = IDX_W + 1;

    typedef enum logic [1:0] {
        MODE_RJ24  = 2'b00,
        MODE_RJ20  = 2'b01,
        MODE_I2S16 = 2'b10,
        MODE_I2S32 = 2'b11
    } fmt_mode_e;

    function automatic logic [CNT_W-1:0] mode_len(fmt_mode_e m);
        case (m)
            MODE_RJ24:  return CNT_W'(24);
            MODE_RJ20:  return CNT_W'(20);
            MODE_I2S16: return CNT_W'(16);
            default:    return CNT_W'(SMP_W);
        endcase
    endfunction

    function automatic logic mode_is_i2s(fmt_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
module sar_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.stg[STAGES-1];

endmodule

// File: rtl/sar_frame_ctrl.sv
`timescale 1ns/1ps
module sar_frame_ctrl
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_s,
    input  logic             ws_s,
    input  fmt_mode_e        mode,
    output logic             bit_stb,
    output logic             boundary,
    output logic             emit,
    output logic [CNT_W-1:0] bit_idx,
    output logic             valid_o,
    output logic             right_o
);

    typedef struct packed {
        logic             sck;
        logic             started;
        logic             primed;
        logic             ws_prev;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             right;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sck   = sck_s;
        st_d.valid = 1'b0;

        bit_stb  = sck_s & ~st_q.sck;
        boundary = bit_stb & st_q.started & (ws_s != st_q.ws_prev);
        emit     = boundary & st_q.primed;
        bit_idx  = st_q.cnt;

        if (bit_stb) begin
            st_d.started = 1'b1;
            st_d.ws_prev = ws_s;
            if (boundary) begin
                st_d.primed = 1'b1;
                st_d.cnt    = '0;
            end else if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (emit) begin
            st_d.valid = 1'b1;
            // Completed half-frame channel: polarity flips between formats.
            st_d.right = mode_is_i2s(mode) ? st_q.ws_prev : ~st_q.ws_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign right_o = st_q.right;

    // Assertion-only history of the last reported channel.
    logic last_right_q, have_last_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_right_q <= 1'b0;
            have_last_q  <= 1'b0;
        end else if (st_q.valid) begin
            last_right_q <= st_q.right;
            have_last_q  <= 1'b1;
        end
    end

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_alternate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && have_last_q) |-> (right_o != last_right_q));

    p_armed_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (st_q.primed && st_q.started));

endmodule

// File: rtl/sar_lane.sv
`timescale 1ns/1ps
module sar_lane
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_mode_e        mode,
    input  logic             bit_stb,
    input  logic             boundary,
    input  logic             emit,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             sd,
    output logic [SMP_W-1:0] smp_o
);

    typedef struct packed {
        logic [SMP_W-1:0] acc;
        logic [SMP_W-1:0] smp;
    } lane_st_t;

    lane_st_t         st_d, st_q;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] sh;
    logic [SMP_W-1:0] wr;
    logic [SMP_W-1:0] aligned;
    logic [IDX_W-1:0] pos;

    always_comb begin
        st_d    = st_q;
        len     = mode_len(mode);
        sh      = CNT_W'(SMP_W) - len;
        pos     = IDX_W'(SMP_W - 1) - bit_idx[IDX_W-1:0];
        wr      = st_q.acc;
        aligned = '0;

        if (bit_stb) begin
            if (mode_is_i2s(mode)) begin
                // Left-justified: place bit at its position from the MSB.
                if (bit_idx < len) wr[pos] = sd;
                if (boundary) begin
                    if (emit) st_d.smp = SMP_W'($signed(wr) >>> sh);
                    st_d.acc = '0;
                end else begin
                    st_d.acc = wr;
                end
            end else begin
                // Right-justified: the newest bit belongs to the new half.
                aligned = st_q.acc << sh;
                if (emit) st_d.smp = SMP_W'($signed(aligned) >>> sh);
                st_d.acc = {st_q.acc[SMP_W-2:0], sd};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o = st_q.smp;

endmodule

// File: rtl/sar_rx.sv
`timescale 1ns/1ps
module sar_rx
    import sar_pkg::*;
#(
    parameter int LANES       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sck_in,
    input  logic                   ws_in,
    input  logic [LANES-1:0]       sd_in,
    input  logic                   fmt_sel,
    input  logic                   len_sel,
    output logic [LANES*SMP_W-1:0] smp_data,
    output logic                   smp_right,
    output logic                   smp_valid
);

    localparam int SYNC_W = LANES + 2;

    logic [SYNC_W-1:0] sync_q;
    logic              sck_s, ws_s;
    logic [LANES-1:0]  sd_s;
    fmt_mode_e         mode;
    logic              bit_stb, boundary, emit;
    logic [CNT_W-1:0]  bit_idx;

    assign mode = fmt_mode_e'({fmt_sel, len_sel});

    // One synchronizer for clock, frame and data keeps them aligned.
    sar_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sd_in, ws_in, sck_in}),
        .q     (sync_q)
    );

    assign sck_s = sync_q[0];
    assign ws_s  = sync_q[1];
    assign sd_s  = sync_q[SYNC_W-1:2];

    sar_frame_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .ws_s     (ws_s),
        .mode     (mode),
        .bit_stb  (bit_stb),
        .boundary (boundary),
        .emit     (emit),
        .bit_idx  (bit_idx),
        .valid_o  (smp_valid),
        .right_o  (smp_right)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sar_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .bit_stb  (bit_stb),
            .boundary (boundary),
            .emit     (emit),
            .bit_idx  (bit_idx),
            .sd       (sd_s[k]),
            .smp_o    (smp_data[k*SMP_W +: SMP_W])
        );

        p_sext_rj24_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && mode == MODE_RJ24) |->
            (smp_data[k*SMP_W+23 +: 9] == {9{smp_data[k*SMP_W+23]}}));

        p_sext_rj20_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && mode == MODE_RJ20) |->
            (smp_data[k*SMP_W+19 +: 13] == {13{smp_data[k*SMP_W+19]}}));

        p_sext_i2s16_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && mode == MODE_I2S16) |->
            (smp_data[k*SMP_W+15 +: 17] == {17{smp_data[k*SMP_W+15]}}));
    end

endmodule

// File: tb/sar_rx_bench.sv
`timescale 1ns/1ps
module sar_rx_bench;

    localparam int LN = 3;
    localparam int MAXS = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck_in = 1'b0;
    logic          ws_in = 1'b0;
    logic [LN-1:0] sd_in = '0;
    logic          fmt_sel = 1'b0;
    logic          len_sel = 1'b0;
    logic [LN*32-1:0] smp_data;
    logic          smp_right;
    logic          smp_valid;

    always #5 clk = ~clk;

    sar_rx u_sar_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_in    (sck_in),
        .ws_in     (ws_in),
        .sd_in     (sd_in),
        .fmt_sel   (fmt_sel),
        .len_sel   (len_sel),
        .smp_data  (smp_data),
        .smp_right (smp_right),
        .smp_valid (smp_valid)
    );

    // {mode[1:0], half length[6:0], I2S word length[6:0], seed[31:0]}
    localparam logic [47:0] VEC [10] = '{
        {2'b00, 7'd32, 7'd0,  32'h8F3A_C215},
        {2'b00, 7'd24, 7'd0,  32'h1234_5678},
        {2'b01, 7'd32, 7'd0,  32'hC0DE_8001},
        {2'b01, 7'd20, 7'd0,  32'h0007_FFFF},
        {2'b10, 7'd16, 7'd16, 32'hA5A5_8F00},
        {2'b10, 7'd32, 7'd16, 32'h5A5A_7123},
        {2'b11, 7'd32, 7'd32, 32'hDEAD_BEEF},
        {2'b11, 7'd24, 7'd24, 32'h0BAD_F00D},
        {2'b11, 7'd40, 7'd32, 32'h7FFF_0001},
        {2'b11, 7'd28, 7'd28, 32'hF0E1_D2C3}
    };

    int errors = 0;
    int checks = 0;
    int cap_cnt = 0;
    int dbl_cnt = 0;
    logic prev_valid = 1'b0;
    logic [LN*32-1:0] cap_data [8];
    logic             cap_right [8];
    logic [LN-1:0]    st_sd [MAXS];
    logic             st_ws [MAXS];

    always @(negedge clk) begin
        if (smp_valid) begin
            if (cap_cnt < 8) begin
                cap_data[cap_cnt]  = smp_data;
                cap_right[cap_cnt] = smp_right;
            end
            cap_cnt = cap_cnt + 1;
            if (prev_valid) dbl_cnt = dbl_cnt + 1;
        end
        prev_valid = smp_valid;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gen_word(logic [31:0] seed, int k, int p);
        return seed ^ (32'(k * 4 + p + 1) * 32'h9E37_79B9);
    endfunction

    function automatic logic [31:0] expect_word(logic [1:0] m, int len, logic [31:0] w);
        logic [31:0] msk;
        case (m)
            2'b00: return {{8{w[23]}}, w[23:0]};
            2'b01: return {{12{w[19]}}, w[19:0]};
            2'b10: return {{16{w[15]}}, w[15:0]};
            default: begin
                if (len >= 32) return w;
                msk = (32'd1 << len) - 32'd1;
                return (w & msk) << (32 - len);
            end
        endcase
    endfunction

    function automatic string data_tag(logic [1:0] m);
        case (m)
            2'b00:   return "R1 R2 R5 R8";
            2'b01:   return "R1 R2 R5 R8";
            2'b10:   return "R1 R2 R6 R8";
            default: return "R1 R6 R7 R8";
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        sck_in = 1'b0;
        repeat (4) @(negedge clk);
        cap_cnt = 0;
        dbl_cnt = 0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Half 0 is a right-channel lead-in, halves 1..4 carry L,R,L,R, half 5 trails.
    task automatic build(input logic [1:0] m, input int h, input int len, input logic [31:0] seed);
        logic rj;
        int nbits;
        rj = ~m[1];
        nbits = (m == 2'b00) ? 24 : 20;
        for (int g = 0; g < MAXS; g++) begin
            st_ws[g] = rj ? ((g / h) % 2 == 1) : ((g / h) % 2 == 0);
            st_sd[g] = {LN{g[0]}};
        end
        for (int hh = 1; hh <= 4; hh++) begin
            for (int k = 0; k < LN; k++) begin
                logic [31:0] w;
                w = gen_word(seed, k, hh - 1);
                if (rj) begin
                    for (int j = 0; j < h; j++) begin
                        if (h - 1 - j < nbits) st_sd[hh*h + j][k] = w[h - 1 - j];
                    end
                end else begin
                    for (int i = 0; i < len; i++) st_sd[hh*h + 1 + i][k] = w[len - 1 - i];
                end
            end
        end
    endtask

    task automatic play(input int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            sck_in = 1'b0;
            ws_in  = st_ws[g];
            sd_in  = st_sd[g];
            repeat (3) @(negedge clk);
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        @(negedge clk);
        sck_in = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check(smp_valid == 1'b0 && smp_right == 1'b0, "R11 reset valid/right",
              {30'd0, smp_right, smp_valid}, 32'd0);
        check(smp_data == '0, "R11 reset data", smp_data[31:0], 32'd0);
        do_reset();

        for (int v = 0; v < 10; v++) begin
            logic [1:0] m;
            int h, len;
            logic [31:0] seed;
            m    = VEC[v][47:46];
            h    = int'(VEC[v][45:39]);
            len  = int'(VEC[v][38:32]);
            seed = VEC[v][31:0];
            fmt_sel = m[1];
            len_sel = m[0];
            do_reset();
            build(m, h, len, seed);
            play(6 * h);
            check(cap_cnt == 4, "R9 R10 pulse count", 32'(cap_cnt), 32'd4);
            check(dbl_cnt == 0, "R9 single-cycle pulse", 32'(dbl_cnt), 32'd0);
            for (int p = 0; p < 4 && p < cap_cnt; p++) begin
                check(cap_right[p] == p[0], m[1] ? "R4 channel polarity" : "R3 channel polarity",
                      {31'd0, cap_right[p]}, {31'd0, p[0]});
                for (int k = 0; k < LN; k++) begin
                    logic [31:0] exp;
                    exp = expect_word(m, len, gen_word(seed, k, p));
                    check(cap_data[p][k*32 +: 32] == exp, data_tag(m),
                          cap_data[p][k*32 +: 32], exp);
                end
            end
        end

        // R10: lead-in half plus one half only arms, no report
        fmt_sel = 1'b0;
        len_sel = 1'b0;
        do_reset();
        build(2'b00, 24, 0, 32'h1111_2222);
        play(2 * 24);
        check(cap_cnt == 0, "R10 first change only arms", 32'(cap_cnt), 32'd0);

        // R11: reset in mid-stream clears held outputs
        do_reset();
        build(2'b00, 24, 0, 32'h8765_4321);
        play(3 * 24);
        check(cap_cnt == 1, "R9 mid-stream pulse", 32'(cap_cnt), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check(smp_data == '0 && smp_valid == 1'b0, "R11 reset clears data",
              smp_data[31:0], 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule